// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block produces the read/write strobe for one programmed-I/O transfer to an IDE drive on a local bus. The host loads up to four byte-wide timing registers. Each byte packs two bus-clock counts: how long the strobe stays asserted (active) and how long the bus then rests (recovery). A transfer request names a channel and a drive. A mapping picks one of the four registers for that request, and the byte is turned into counts. The strobe is then asserted for the active count. It is released for the recovery count, and busy stays high until the recovery count ends.

The byte encoding is inverted and offset. Its meaning depends on the controller variant: dual-channel, or single-channel. In the single-channel variant it also depends on a strap that tells whether the bus runs at 33 MHz or slower. A decoded count outside the legal range for the selected variant is clamped to that range, and a sticky flag records that a clamp happened. Counts are captured when a request is accepted, so a register write made during a transfer only takes effect at the next access.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset `strobe`, `busy` and `clamp_seen` are 0. Every timing register holds 8'h00, which decodes to the longest timing of each variant: dual 17 active / 15 recovery, single slow 9 / 15, single fast 8 / 18.
- R2: A write is taken only when `cfg_wr_en` is 1, `cfg_wr_addr[0]` is 0 and `cfg_wr_addr[6:2]` is 5'b01100. The register index is {`cfg_wr_addr[1]`, `cfg_wr_addr[7]`}. Writes to any other address leave every register unchanged.
- R3: A request (`req_valid` high while `busy` is low) is accepted on that clock edge. From the next cycle, `strobe` is high for exactly A cycles and `busy` is high for exactly A+R cycles, where A is the active count and R is the recovery count. `strobe` is never high without `busy`.
- R4: Dual-channel variant (`dual_mode`=1): A = 17 - byte[3:0] and R = 15 - byte[7:4]. The legal ranges are A in 2..17 and R in 2..15.
- R5: Single-channel variant with `slow_bus`=1: A = 9 - byte[2:0] (2..9) and R = 15 - byte[7:4] (0..15). Byte bit 3 is ignored. R = 0 means `busy` drops when the strobe ends.
- R6: Single-channel variant with `slow_bus`=0: A = 8 - byte[2:0] (1..8) and R = 18 - byte[7:4] (3..18).
- R7: The register index for a request is {slot, `bank_hi`}. In dual mode with `primary_only`=0, slot = `req_chan`. In dual mode with `primary_only`=1, slot = `req_drive`. In single mode, slot = 0.
- R8: A request that arrives while `busy` is high is ignored. The current transfer keeps its length, and no new strobe follows it.
- R9: A register write during a transfer does not change that transfer's counts. The next accepted request uses the new value.
- R10: A decoded count below its minimum is raised to the minimum, and one above its maximum is lowered to the maximum. When an accepted request needed a clamp, `clamp_seen` rises on the accept edge and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Timing register write strobe |
| cfg_wr_addr | input | 8 | Host write address |
| cfg_wr_data | input | 8 | Timing byte to store |
| bank_hi | input | 1 | Strap: selects the upper register bank (index bit 0) |
| dual_mode | input | 1 | 1 = dual-channel variant, 0 = single-channel variant |
| primary_only | input | 1 | Dual mode: 1 = the two drives of the primary port each get their own register |
| slow_bus | input | 1 | Speed strap: 1 = bus at or below 33 MHz |
| req_valid | input | 1 | Access request |
| req_chan | input | 1 | Channel of the access |
| req_drive | input | 1 | Drive number of the access |
| strobe | output | 1 | Read/write strobe to the drive |
| busy | output | 1 | High from acceptance to the end of recovery |
| clamp_seen | output | 1 | Sticky: a decoded count was clamped |

## Verification
A corrupted counter or phase register shows up on the first transfer that follows. The strobe width or the busy width then differs from A or A+R by at least one cycle, and this is visible on the cycle the strobe or busy falls. A wrong register index or decode variant also appears within one transfer, as a width that belongs to another register or another formula. For that reason, each register is loaded with a value whose widths differ from its neighbours'. A stuck or lost clamp flag is visible on the cycle after the accepting edge.

// File: rtl/pio_strobe_pkg.sv
`timescale 1ns/1ps
package pio_strobe_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_ACTIVE  = 2'd1,
      SEQ_RECOVER = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      VAR_DUAL        = 2'd0,
      VAR_SINGLE_SLOW = 2'd1,
      VAR_SINGLE_FAST = 2'd2
   } pio_variant_e;

   // encoding offsets and legal ranges, per variant
   localparam int DUAL_ACT_BASE = 17;
   localparam int DUAL_ACT_LO   = 2;
   localparam int DUAL_ACT_HI   = 17;
   localparam int DUAL_REC_BASE = 15;
   localparam int DUAL_REC_LO   = 2;
   localparam int DUAL_REC_HI   = 15;

   localparam int SLOW_ACT_BASE = 9;
   localparam int SLOW_ACT_LO   = 2;
   localparam int SLOW_ACT_HI   = 9;
   localparam int SLOW_REC_BASE = 15;
   localparam int SLOW_REC_LO   = 0;
   localparam int SLOW_REC_HI   = 15;

   localparam int FAST_ACT_BASE = 8;
   localparam int FAST_ACT_LO   = 1;
   localparam int FAST_ACT_HI   = 8;
   localparam int FAST_REC_BASE = 18;
   localparam int FAST_REC_LO   = 3;
   localparam int FAST_REC_HI   = 18;

   localparam int LONGEST_COUNT = 18;

endpackage

// File: rtl/pio_timing_regfile.sv
`timescale 1ns/1ps
module pio_timing_regfile #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_REGS  = 4,
   parameter int unsigned REG_W     = 8,
   parameter logic [REG_W-1:0] RESET_VAL = '0,
   parameter logic [ADDR_W-4:0] BASE_TAG = 5'b01100
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [REG_W-1:0]            wr_data,
   input  logic [$clog2(NUM_REGS)-1:0] rd_idx,
   output logic [REG_W-1:0]            rd_data
);
   localparam int unsigned IDX_W    = $clog2(NUM_REGS);
   localparam int unsigned BANK_BIT = ADDR_W - 1;
   localparam int unsigned SLOT_BIT = 1;

   if (NUM_REGS != 4) begin : g_bad_count
      $error("pio_timing_regfile: the address decode serves exactly four registers");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("pio_timing_regfile: address must be at least 8 bits");
   end

   logic             addr_hit;
   logic [IDX_W-1:0] wr_idx;
   logic [REG_W-1:0] regs_q [NUM_REGS];

   assign addr_hit = wr_en && !wr_addr[0] && (wr_addr[ADDR_W-2:2] == BASE_TAG);
   assign wr_idx   = {wr_addr[SLOT_BIT], wr_addr[BANK_BIT]};

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs_q[gi] <= RESET_VAL;
         end else if (addr_hit && (wr_idx == IDX_W'(gi))) begin
            regs_q[gi] <= wr_data;
         end
      end
   end

   assign rd_data = regs_q[rd_idx];

endmodule

// File: rtl/pio_slot_map.sv
`timescale 1ns/1ps
module pio_slot_map #(
   parameter int unsigned IDX_W = 2
) (
   input  logic             dual_mode,
   input  logic             primary_only,
   input  logic             bank_hi,
   input  logic             req_chan,
   input  logic             req_drive,
   output logic [IDX_W-1:0] reg_idx
);
   if (IDX_W != 2) begin : g_bad_idx
      $error("pio_slot_map: index is slot bit plus bank bit");
   end

   logic slot;

   always_comb begin
      if (!dual_mode)        slot = 1'b0;
      else if (primary_only) slot = req_drive;
      else                   slot = req_chan;
   end

   assign reg_idx = {slot, bank_hi};

endmodule

// File: rtl/pio_timing_decode.sv
`timescale 1ns/1ps
module pio_timing_decode
   import pio_strobe_pkg::*;
#(
   parameter int unsigned CNT_W          = 5,
   parameter bit          SINGLE_CAPABLE = 1'b1
) (
   input  logic [7:0]       treg,
   input  logic             dual_mode,
   input  logic             slow_bus,
   output logic [CNT_W-1:0] act_cnt,
   output logic [CNT_W-1:0] rec_cnt,
   output logic             clamped
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if (CNT_MAX < LONGEST_COUNT) begin : g_bad_width
      $error("pio_timing_decode: counter too narrow for the longest phase");
   end

   pio_variant_e variant;

   if (SINGLE_CAPABLE) begin : g_multi
      always_comb begin
         if (dual_mode)     variant = VAR_DUAL;
         else if (slow_bus) variant = VAR_SINGLE_SLOW;
         else               variant = VAR_SINGLE_FAST;
      end
   end else begin : g_dual_only
      assign variant = VAR_DUAL;
   end

   int act_base, act_lo, act_hi, act_field, act_raw, act_sat;
   int rec_base, rec_lo, rec_hi, rec_field, rec_raw, rec_sat;
   logic act_clip, rec_clip;

   always_comb begin
      rec_field = int'(treg[7:4]);
      case (variant)
         VAR_SINGLE_SLOW: begin
            act_field = int'(treg[2:0]);
            act_base = SLOW_ACT_BASE; act_lo = SLOW_ACT_LO; act_hi = SLOW_ACT_HI;
            rec_base = SLOW_REC_BASE; rec_lo = SLOW_REC_LO; rec_hi = SLOW_REC_HI;
         end
         VAR_SINGLE_FAST: begin
            act_field = int'(treg[2:0]);
            act_base = FAST_ACT_BASE; act_lo = FAST_ACT_LO; act_hi = FAST_ACT_HI;
            rec_base = FAST_REC_BASE; rec_lo = FAST_REC_LO; rec_hi = FAST_REC_HI;
         end
         default: begin
            act_field = int'(treg[3:0]);
            act_base = DUAL_ACT_BASE; act_lo = DUAL_ACT_LO; act_hi = DUAL_ACT_HI;
            rec_base = DUAL_REC_BASE; rec_lo = DUAL_REC_LO; rec_hi = DUAL_REC_HI;
         end
      endcase

      act_raw = act_base - act_field;
      rec_raw = rec_base - rec_field;

      act_clip = (act_raw < act_lo) || (act_raw > act_hi);
      rec_clip = (rec_raw < rec_lo) || (rec_raw > rec_hi);

      if (act_raw < act_lo)      act_sat = act_lo;
      else if (act_raw > act_hi) act_sat = act_hi;
      else                       act_sat = act_raw;

      if (rec_raw < rec_lo)      rec_sat = rec_lo;
      else if (rec_raw > rec_hi) rec_sat = rec_hi;
      else                       rec_sat = rec_raw;

      act_cnt = CNT_W'(act_sat);
      rec_cnt = CNT_W'(rec_sat);
      clamped = act_clip || rec_clip;
   end

endmodule

// File: rtl/pio_strobe_seq.sv
`timescale 1ns/1ps
module pio_strobe_seq
   import pio_strobe_pkg::*;
#(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [CNT_W-1:0] act_cnt,
   input  logic [CNT_W-1:0] rec_cnt,
   input  logic             clamped,
   output logic             strobe,
   output logic             busy,
   output logic             clamp_seen
);
   seq_state_e       state_q;
   logic [CNT_W-1:0] left_q;
   logic [CNT_W-1:0] rec_q;
   logic             flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         left_q  <= '0;
         rec_q   <= '0;
         flag_q  <= 1'b0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (req_valid) begin
                  state_q <= SEQ_ACTIVE;
                  left_q  <= act_cnt - CNT_W'(1);
                  rec_q   <= rec_cnt;
                  if (clamped) flag_q <= 1'b1;
               end
            end
            SEQ_ACTIVE: begin
               if (left_q != '0) begin
                  left_q <= left_q - CNT_W'(1);
               end else if (rec_q == '0) begin
                  state_q <= SEQ_IDLE;
               end else begin
                  state_q <= SEQ_RECOVER;
                  left_q  <= rec_q - CNT_W'(1);
               end
            end
            SEQ_RECOVER: begin
               if (left_q != '0) left_q  <= left_q - CNT_W'(1);
               else              state_q <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign strobe     = (state_q == SEQ_ACTIVE);
   assign busy       = (state_q != SEQ_IDLE);
   assign clamp_seen = flag_q;

endmodule

// File: rtl/pio_strobe_gen.sv
`timescale 1ns/1ps
module pio_strobe_gen #(
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned NUM_REGS       = 4,
   parameter int unsigned CNT_W          = 5,
   parameter bit          SINGLE_CAPABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [ADDR_W-1:0] cfg_wr_addr,
   input  logic [7:0]        cfg_wr_data,
   input  logic              bank_hi,
   input  logic              dual_mode,
   input  logic              primary_only,
   input  logic              slow_bus,
   input  logic              req_valid,
   input  logic              req_chan,
   input  logic              req_drive,
   output logic              strobe,
   output logic              busy,
   output logic              clamp_seen
);
   localparam int unsigned IDX_W = $clog2(NUM_REGS);

   logic [IDX_W-1:0] sel_idx;
   logic [7:0]       sel_byte;
   logic [CNT_W-1:0] act_cnt;
   logic [CNT_W-1:0] rec_cnt;
   logic             clamped;

   pio_timing_regfile #(
      .ADDR_W   (ADDR_W),
      .NUM_REGS (NUM_REGS),
      .REG_W    (8),
      .RESET_VAL(8'h00)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en),
      .wr_addr(cfg_wr_addr),
      .wr_data(cfg_wr_data),
      .rd_idx (sel_idx),
      .rd_data(sel_byte)
   );

   pio_slot_map #(.IDX_W(IDX_W)) u_map (
      .dual_mode   (dual_mode),
      .primary_only(primary_only),
      .bank_hi     (bank_hi),
      .req_chan    (req_chan),
      .req_drive   (req_drive),
      .reg_idx     (sel_idx)
   );

   pio_timing_decode #(
      .CNT_W         (CNT_W),
      .SINGLE_CAPABLE(SINGLE_CAPABLE)
   ) u_dec (
      .treg     (sel_byte),
      .dual_mode(dual_mode),
      .slow_bus (slow_bus),
      .act_cnt  (act_cnt),
      .rec_cnt  (rec_cnt),
      .clamped  (clamped)
   );

   pio_strobe_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .act_cnt   (act_cnt),
      .rec_cnt   (rec_cnt),
      .clamped   (clamped),
      .strobe    (strobe),
      .busy      (busy),
      .clamp_seen(clamp_seen)
   );

endmodule

// File: rtl/pio_strobe_gen_chk.sv
`timescale 1ns/1ps
module pio_strobe_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic strobe,
   input logic busy,
   input logic clamp_seen
);
   AST_STROBE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> busy);                                          // R3
   AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> (busy && strobe));                // R3
   AST_BUSY_OPENS_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> strobe);                                   // R3
   AST_NO_STROBE_IN_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !strobe) |=> !strobe);                            // R8
   AST_CLAMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_seen |=> clamp_seen);                                // R10
   AST_CLAMP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clamp_seen) |-> $rose(busy));                        // R10
endmodule

bind pio_strobe_gen pio_strobe_gen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .strobe    (strobe),
   .busy      (busy),
   .clamp_seen(clamp_seen)
);

// File: tb/pio_strobe_gen_tb.sv
`timescale 1ns/1ps
module pio_strobe_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr_en = 1'b0;
   logic [7:0] cfg_wr_addr = 8'h00;
   logic [7:0] cfg_wr_data = 8'h00;
   logic       bank_hi = 1'b0;
   logic       dual_mode = 1'b1;
   logic       primary_only = 1'b0;
   logic       slow_bus = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_chan = 1'b0;
   logic       req_drive = 1'b0;
   logic       strobe, busy, clamp_seen;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pio_strobe_gen u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
      .bank_hi(bank_hi), .dual_mode(dual_mode), .primary_only(primary_only),
      .slow_bus(slow_bus), .req_valid(req_valid), .req_chan(req_chan),
      .req_drive(req_drive), .strobe(strobe), .busy(busy), .clamp_seen(clamp_seen)
   );

   // {dual, slow, byte[8], active[5], busy_total[5]... } packed: dual|slow|byte|act|rec|clamp
   localparam int NV = 11;
   localparam logic [20:0] VEC [NV] = '{
      {1'b1, 1'b0, 8'h00, 5'd17, 5'd15, 1'b0},   // R4 longest
      {1'b1, 1'b0, 8'h5A, 5'd7,  5'd10, 1'b0},   // R4
      {1'b1, 1'b0, 8'hDF, 5'd2,  5'd2,  1'b0},   // R4 shortest legal
      {1'b0, 1'b1, 8'h08, 5'd9,  5'd15, 1'b0},   // R5
      {1'b0, 1'b1, 8'hFB, 5'd6,  5'd0,  1'b0},   // R5 zero recovery, bit3 ignored
      {1'b0, 1'b1, 8'h2F, 5'd2,  5'd13, 1'b0},   // R5
      {1'b0, 1'b0, 8'h08, 5'd8,  5'd18, 1'b0},   // R6 longest
      {1'b0, 1'b0, 8'hF7, 5'd1,  5'd3,  1'b0},   // R6 shortest
      {1'b0, 1'b0, 8'h3D, 5'd3,  5'd15, 1'b0},   // R6
      {1'b1, 1'b0, 8'hE3, 5'd14, 5'd2,  1'b1},   // R10 recovery 1 raised to 2
      {1'b1, 1'b0, 8'hF0, 5'd17, 5'd2,  1'b1}    // R10 recovery 0 raised to 2
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   // issue one request, count strobe-high and busy-high cycles; optional pokes
   task automatic run_access(input logic ch, input logic dr, input int poke_req,
                             input int poke_wr, input logic [7:0] wdat,
                             output int na, output int nb);
      int n;
      na = 0; nb = 0; n = 0;
      @(negedge clk);
      req_chan = ch; req_drive = dr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (busy && n < 100) begin
         if (strobe) na++;
         nb++;
         n++;
         req_valid = (n == poke_req);
         if (n == poke_wr) begin
            cfg_wr_en = 1'b1; cfg_wr_addr = 8'h30; cfg_wr_data = wdat;
         end else begin
            cfg_wr_en = 1'b0;
         end
         @(negedge clk);
      end
      req_valid = 1'b0; cfg_wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 strobe in reset", int'(strobe), 0);
      check("R1 busy in reset", int'(busy), 0);
      check("R1 clamp_seen in reset", int'(clamp_seen), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      int a, b;
      do_reset();

      // R1: reset value decodes to the longest dual timing
      dual_mode = 1'b1;
      run_access(1'b0, 1'b0, 0, 0, 8'h00, a, b);
      check("R1 reset active", a, 17);
      check("R1 reset busy", b, 32);

      // table of decode vectors: R3 R4 R5 R6 R10
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         dual_mode = VEC[i][20];
         slow_bus  = VEC[i][19];
         write_reg(8'h30, VEC[i][18:11]);
         run_access(1'b0, 1'b0, 0, 0, 8'h00, a, b);
         check($sformatf("R3 vec%0d active", i), a, int'(VEC[i][10:6]));
         check($sformatf("R3 vec%0d busy", i), b, int'(VEC[i][10:6]) + int'(VEC[i][5:1]));
         check($sformatf("R10 vec%0d clamp", i), int'(clamp_seen), int'(VEC[i][0]));
      end

      // R2: address decode rejects odd and foreign addresses
      dual_mode = 1'b1; slow_bus = 1'b0;
      write_reg(8'h30, 8'hDF);
      write_reg(8'h31, 8'h00);
      write_reg(8'h34, 8'h00);
      write_reg(8'h70, 8'h00);
      run_access(1'b0, 1'b0, 0, 0, 8'h00, a, b);
      check("R2 ignored writes active", a, 2);
      check("R2 ignored writes busy", b, 4);

      // R7: register selection by mode
      write_reg(8'hB0, 8'h5A);   // index 1: 7/10
      write_reg(8'h32, 8'h00);   // index 2: 17/15
      write_reg(8'hB2, 8'h9C);   // index 3: 5/6
      primary_only = 1'b0; bank_hi = 1'b0;
      run_access(1'b1, 1'b0, 0, 0, 8'h00, a, b);
      check("R7 dual chan1 -> idx2", a, 17);
      run_access(1'b0, 1'b1, 0, 0, 8'h00, a, b);
      check("R7 dual chan0 drive1 -> idx0", a, 2);
      primary_only = 1'b1;
      run_access(1'b0, 1'b1, 0, 0, 8'h00, a, b);
      check("R7 primary_only drive1 -> idx2", a, 17);
      run_access(1'b1, 1'b0, 0, 0, 8'h00, a, b);
      check("R7 primary_only drive0 -> idx0", a, 2);
      primary_only = 1'b0; bank_hi = 1'b1;
      run_access(1'b0, 1'b0, 0, 0, 8'h00, a, b);
      check("R7 bank_hi chan0 -> idx1", b, 17);
      run_access(1'b1, 1'b0, 0, 0, 8'h00, a, b);
      check("R7 bank_hi chan1 -> idx3", b, 11);
      bank_hi = 1'b0; dual_mode = 1'b0; slow_bus = 1'b1;
      run_access(1'b1, 1'b1, 0, 0, 8'h00, a, b);
      check("R7 single chan1 drive1 -> idx0 active", a, 2);
      check("R7 single chan1 drive1 -> idx0 busy", b, 4);

      // R8: requests while busy are ignored
      dual_mode = 1'b1; slow_bus = 1'b0;
      write_reg(8'h30, 8'h5A);
      run_access(1'b0, 1'b0, 3, 0, 8'h00, a, b);
      check("R8 poke during active: active", a, 7);
      check("R8 poke during active: busy", b, 17);
      check("R8 idle after", int'(busy), 0);
      run_access(1'b0, 1'b0, 12, 0, 8'h00, a, b);
      check("R8 poke during recovery: busy", b, 17);
      @(negedge clk);
      check("R8 no new strobe", int'(strobe), 0);
      check("R8 stays idle", int'(busy), 0);

      // R9: write mid-transfer only affects the next access
      write_reg(8'h30, 8'h00);
      run_access(1'b0, 1'b0, 0, 5, 8'hDF, a, b);
      check("R9 current active", a, 17);
      check("R9 current busy", b, 32);
      run_access(1'b0, 1'b0, 0, 0, 8'h00, a, b);
      check("R9 next active", a, 2);
      check("R9 next busy", b, 4);

      // R10 sticky flag, then R1 reset clears it and restores registers
      check("R10 flag still set", int'(clamp_seen), 1);
      do_reset();
      run_access(1'b0, 1'b0, 0, 0, 8'h00, a, b);
      check("R1 post-reset active", a, 17);
      check("R1 post-reset busy", b, 32);
      check("R10 flag cleared by reset", int'(clamp_seen), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #4000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule